// File: doc/BRIEF.md
# Closed-Page SDR SDRAM Controller

This block connects one simple host port to a 16-bit single-data-rate SDRAM clocked at 100 MHz. After reset it powers up the memory. It holds a long stretch of NOPs, precharges every bank, issues two auto-refreshes and programs the mode register. Only after that does it report itself ready.

In normal operation it serves one host access at a time. Every access uses a fixed, cycle-exact command template:

- the template opens the addressed row;
- it moves one burst of two 16-bit words;
- it closes the row with a precharge.

No row stays open between requests. A free-running interval timer raises refresh requests. A pending refresh takes precedence over the host at the next idle cycle.

The host presents a request with a write flag, a flat address split into bank, row and column, and a 32-bit write word. The request is taken on a clock edge where busy is low. Read results return as a 32-bit word with a one-cycle valid strobe.

Top module: `sdr_closed_ctrl`

## Requirements
- R1: After reset, ready is low and only NOPs issue for INIT_CYCLES cycles. Then a PRECHARGE with address bit 10 high issues. Three cycles after it comes the first REFRESH, seven cycles later the second REFRESH, and seven cycles after that a LOAD MODE. Ready rises three cycles after LOAD MODE and stays high until reset.
- R2: The LOAD MODE command carries address bits [2:0]=001 (burst of two), bits [6:4]=CAS_LAT, and all other address bits zero.
- R3: Every REFRESH is followed by exactly six NOP cycles before any other command.
- R4: Once ready is high, a refresh is due every REF_PERIOD cycles. A due refresh is served before a waiting host request. Consecutive REFRESH commands in normal operation are no more than REF_PERIOD+9 cycles apart.
- R5: A read runs ACTIVATE, NOP, NOP, READ, NOP, PRECHARGE, NOP, NOP. ACTIVATE carries the bank (top BANK_W address bits) and the row (next ROW_W bits). READ carries the column (low COL_W bits) with address bit 10 low. PRECHARGE targets the same bank.
- R6: A write runs ACTIVATE, NOP, NOP, WRITE, NOP, NOP, PRECHARGE, NOP, NOP. The data bus is driven only in the WRITE cycle, with write bits [15:0], and in the cycle after it, with bits [31:16].
- R7: The word on the data bus CAS_LAT cycles after READ becomes read bits [15:0]. The word one cycle later becomes bits [31:16]. The valid strobe is high for exactly one cycle, CAS_LAT+2 cycles after READ.
- R8: Busy is low only when the controller is idle, ready and has no refresh due. A request is taken on an edge where request is high and busy is low, and ACTIVATE follows in the next cycle. A request raised while busy is high is not served until busy drops, and it is served once.
- R9: A READ or WRITE issues only while a row is open. An ACTIVATE issues only after the previous row has been precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | BANK_W+ROW_W+COL_W | Flat address {bank, row, column} |
| host_wdata | input | 2*DQ_W | Write word, low half goes first |
| host_busy | output | 1 | High while no request can be taken |
| host_ready | output | 1 | Power-up sequence finished |
| host_rdata | output | 2*DQ_W | Read word |
| host_rvalid | output | 1 | One-cycle strobe for host_rdata |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row/column/mode address |
| sd_dq_out | output | DQ_W | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | DQ_W | Data returned by the memory |

## Verification
The bench drives a behavioural memory responder and targets four corner cases.

- **Power-up order and spacing.** A controller that skips or reorders a step would let ready rise at the wrong cycle or program a wrong mode word.
- **Command templates.** The bench checks every cycle of every access template, including the extra write-recovery NOP. A design that precharges too early, or returns to idle a cycle too soon, trips the per-template comparison.
- **Read-data alignment.** The bench checks the valid strobe position and the order of the two data halves. An off-by-one capture would return swapped or stale data.
- **Refresh behaviour.** Refresh gaps are measured while traffic runs and while the host is silent, and requests held during power-up and busy periods must not create extra activations.

// File: rtl/sdr_closed_ctrl.sv
module sdr_closed_ctrl #(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int DQ_W        = 16,
  parameter int CAS_LAT     = 2,
  parameter int INIT_CYCLES = 20000,
  parameter int REF_PERIOD  = 68
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_req,
  input  logic                          host_we,
  input  logic [BANK_W+ROW_W+COL_W-1:0] host_addr,
  input  logic [2*DQ_W-1:0]             host_wdata,
  output logic                          host_busy,
  output logic                          host_ready,
  output logic [2*DQ_W-1:0]             host_rdata,
  output logic                          host_rvalid,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DQ_W-1:0]               sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DQ_W-1:0]               sd_dq_in
);
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int RW = $clog2(REF_PERIOD + 1);
  localparam int GW = $clog2(REF_PERIOD + 32);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  localparam logic [3:0] PALL_LAST = 4'd2;
  localparam logic [3:0] REF_LAST  = 4'd6;
  localparam logic [3:0] MRS_LAST  = 4'd2;
  localparam logic [3:0] RD_LAST   = 4'd7;
  localparam logic [3:0] WR_LAST   = 4'd8;
  localparam logic [3:0] XFER_STEP = 4'd3;
  localparam logic [3:0] RD_PRE    = 4'd5;
  localparam logic [3:0] WR_PRE    = 4'd6;
  localparam logic [3:0] CAP_LO    = 4'(3 + CAS_LAT);
  localparam logic [3:0] CAP_HI    = 4'(4 + CAS_LAT);
  localparam logic [6:0] MODE_WORD = {3'(CAS_LAT), 4'b0001};

  typedef enum logic [2:0] {S_WAIT, S_PALL, S_IREF, S_MRS, S_IDLE, S_ACC, S_REF} state_t;

  state_t              state;
  logic [3:0]          step;
  logic [IW-1:0]       init_cnt;
  logic                iref_second;
  logic [RW-1:0]       ref_cnt;
  logic                ref_pend;
  logic                ready;
  logic                lat_we;
  logic [BANK_W-1:0]   lat_ba;
  logic [ROW_W-1:0]    lat_row;
  logic [COL_W-1:0]    lat_col;
  logic [2*DQ_W-1:0]   lat_wdata;
  logic [2*DQ_W-1:0]   rdata;
  logic                rvalid;
  logic [3:0]          cmd;

  wire idle_free = (state == S_IDLE) && !ref_pend;
  wire accept    = idle_free && host_req;
  wire acc_last  = lat_we ? (step == WR_LAST) : (step == RD_LAST);
  wire pre_step  = lat_we ? (step == WR_PRE) : (step == RD_PRE);

  assign host_busy   = !idle_free;
  assign host_ready  = ready;
  assign host_rdata  = rdata;
  assign host_rvalid = rvalid;
  assign sd_cke      = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_WAIT;
      step        <= '0;
      init_cnt    <= '0;
      iref_second <= 1'b0;
      ref_cnt     <= '0;
      ref_pend    <= 1'b0;
      ready       <= 1'b0;
      lat_we      <= 1'b0;
      lat_ba      <= '0;
      lat_row     <= '0;
      lat_col     <= '0;
      lat_wdata   <= '0;
      rdata       <= '0;
      rvalid      <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        S_WAIT:
          if (init_cnt == IW'(INIT_CYCLES - 1)) begin
            state <= S_PALL;
            step  <= '0;
          end else begin
            init_cnt <= init_cnt + 1'b1;
          end
        S_PALL:
          if (step == PALL_LAST) begin
            state <= S_IREF;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        S_IREF:
          if (step == REF_LAST) begin
            step <= '0;
            if (iref_second) state <= S_MRS;
            iref_second <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        S_MRS:
          if (step == MRS_LAST) begin
            state <= S_IDLE;
            step  <= '0;
            ready <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        S_IDLE:
          if (ref_pend) begin
            state    <= S_REF;
            step     <= '0;
            ref_pend <= 1'b0;
          end else if (host_req) begin
            state     <= S_ACC;
            step      <= '0;
            lat_we    <= host_we;
            lat_ba    <= host_addr[AW-1 -: BANK_W];
            lat_row   <= host_addr[COL_W +: ROW_W];
            lat_col   <= host_addr[COL_W-1:0];
            lat_wdata <= host_wdata;
          end
        S_ACC: begin
          if (!lat_we && step == CAP_LO) rdata[DQ_W-1:0] <= sd_dq_in;
          if (!lat_we && step == CAP_HI) begin
            rdata[2*DQ_W-1:DQ_W] <= sd_dq_in;
            rvalid               <= 1'b1;
          end
          if (acc_last) begin
            state <= S_IDLE;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_REF:
          if (step == REF_LAST) begin
            state <= S_IDLE;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        default: state <= S_WAIT;
      endcase
      if (ready) begin
        if (ref_cnt == RW'(REF_PERIOD - 1)) begin
          ref_cnt  <= '0;
          ref_pend <= 1'b1;
        end else begin
          ref_cnt <= ref_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd       = C_NOP;
    sd_ba     = '0;
    sd_addr   = '0;
    sd_dq_out = '0;
    sd_dq_oe  = 1'b0;
    case (state)
      S_PALL:
        if (step == '0) begin
          cmd         = C_PRE;
          sd_addr[10] = 1'b1;
        end
      S_IREF, S_REF:
        if (step == '0) cmd = C_REF;
      S_MRS:
        if (step == '0) begin
          cmd     = C_MRS;
          sd_addr = {{(ROW_W-7){1'b0}}, MODE_WORD};
        end
      S_ACC: begin
        sd_ba = lat_ba;
        if (step == '0) begin
          cmd     = C_ACT;
          sd_addr = lat_row;
        end else if (step == XFER_STEP) begin
          cmd     = lat_we ? C_WR : C_RD;
          sd_addr = {{(ROW_W-COL_W){1'b0}}, lat_col};
          if (lat_we) begin
            sd_dq_oe  = 1'b1;
            sd_dq_out = lat_wdata[DQ_W-1:0];
          end
        end else if (step == XFER_STEP + 4'd1 && lat_we) begin
          sd_dq_oe  = 1'b1;
          sd_dq_out = lat_wdata[2*DQ_W-1:DQ_W];
        end else if (pre_step) begin
          cmd = C_PRE;
        end
      end
      default: ;
    endcase
  end

  logic          row_open;
  logic          ref_seen;
  logic [GW-1:0] since_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open  <= 1'b0;
      ref_seen  <= 1'b0;
      since_ref <= '0;
    end else begin
      if (cmd == C_ACT) row_open <= 1'b1;
      else if (cmd == C_PRE) row_open <= 1'b0;
      if (cmd == C_REF) begin
        since_ref <= GW'(1);
        ref_seen  <= ready;
      end else if (since_ref != '1) begin
        since_ref <= since_ref + 1'b1;
      end
    end
  end

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R1
  AST_REF_NOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |=> (cmd == C_NOP) ##1 (cmd == C_NOP) ##1 (cmd == C_NOP)
                       ##1 (cmd == C_NOP) ##1 (cmd == C_NOP) ##1 (cmd == C_NOP)); // R3
  AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && ref_seen) |-> (since_ref <= GW'(REF_PERIOD + 9))); // R4
  AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == C_WR || $past(cmd) == C_WR)); // R6
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid); // R7
  AST_ACCEPT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy) |=> (cmd == C_ACT)); // R8
  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> !row_open); // R9
  AST_XFER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> row_open); // R9
endmodule

// File: tb/sim_sdr_closed_ctrl.sv
module sim_sdr_closed_ctrl;
  localparam int BW = 2, RWD = 13, CW = 9, DW = 16, CL = 2, INIT = 40, RP = 68;
  localparam int AW = BW + RWD + CW;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, h_we = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [2*DW-1:0] h_wd = '0;
  logic busy, ready, rvalid, cke, cs_n, ras_n, cas_n, we_n, oe;
  logic [2*DW-1:0] rdata;
  logic [BW-1:0] ba;
  logic [RWD-1:0] sa;
  logic [DW-1:0] dq_out;
  logic [DW-1:0] dq_in = '0;

  always #2.5 clk = ~clk;

  sdr_closed_ctrl #(.BANK_W(BW), .ROW_W(RWD), .COL_W(CW), .DQ_W(DW), .CAS_LAT(CL),
                    .INIT_CYCLES(INIT), .REF_PERIOD(RP)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(h_we), .host_addr(h_addr),
    .host_wdata(h_wd), .host_busy(busy), .host_ready(ready), .host_rdata(rdata),
    .host_rvalid(rvalid), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_addr(sa), .sd_dq_out(dq_out),
    .sd_dq_oe(oe), .sd_dq_in(dq_in));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] tmpl(input logic we, input int pos);
    if (pos == 0) return ACT;
    if (pos == 3) return we ? WR : RD;
    if (pos == (we ? 6 : 5)) return PRE;
    return NOP;
  endfunction

  function automatic logic [15:0] fill(input int key);
    return 16'(key) ^ 16'h5A5A;
  endfunction

  logic [15:0] mem [int];
  logic [31:0] shadow [int];
  logic [RWD-1:0] open_row [4];
  int cyc = 0, rd_t = -100, rd_key = 0, wr_t = -100, wr_key = 0;
  int init_n = 0, ev_cyc [4], ready_cyc = -1, act_before_ready = 0, act_total = 0;
  logic [3:0] ev_cmd [4];
  logic [RWD-1:0] ev_addr [4];
  int acc_pos = -1, acc_err = 0, ref_pos = -1, last_ref = -1;
  logic cur_we = 1'b0;
  logic [BW-1:0] m_ba;
  logic [RWD-1:0] m_row;
  logic [CW-1:0] m_col;
  logic m_a10;

  function automatic int key_of(input logic [BW-1:0] b, input logic [RWD-1:0] r, input logic [CW-1:0] c);
    return int'({b, r, c});
  endfunction

  always @(negedge clk) begin
    logic [3:0] c;
    int k;
    if (rst_n) begin
      cyc++;
      c = {cs_n, ras_n, cas_n, we_n};
      if (ready && ready_cyc < 0) ready_cyc = cyc;
      if (!ready && c != NOP && init_n < 4) begin
        ev_cmd[init_n] = c; ev_cyc[init_n] = cyc; ev_addr[init_n] = sa; init_n++;
      end
      if (c == ACT) begin
        act_total++;
        if (!ready) act_before_ready++;
        open_row[ba] = sa; m_ba = ba; m_row = sa;
      end
      if (c == RD || c == WR) begin m_col = sa[CW-1:0]; m_a10 = sa[10]; end
      if (c == RD) begin rd_t = cyc; rd_key = key_of(ba, open_row[ba], sa[CW-1:0]); end
      if (c == WR) begin
        wr_t = cyc; wr_key = key_of(ba, open_row[ba], sa[CW-1:0]);
        chk(oe, "R6 oe on WRITE", oe, 1);
        mem[wr_key] = dq_out;
      end else if (cyc == wr_t + 1) begin
        chk(oe, "R6 oe after WRITE", oe, 1);
        mem[wr_key ^ 1] = dq_out;
      end
      if (ready && acc_pos > 0) begin
        if (c != tmpl(cur_we, acc_pos)) acc_err++;
        acc_pos++;
        if (acc_pos == (cur_we ? 9 : 8)) begin
          chk(acc_err == 0, cur_we ? "R6 write template" : "R5 read template", acc_err, 0);
          acc_pos = -1;
        end
      end else if (ready && c == ACT) begin
        acc_pos = 1; acc_err = 0;
      end
      if (ready && ref_pos > 0) begin
        if (c != NOP) acc_err++;
        ref_pos++;
        if (ref_pos == 7) begin
          chk(acc_err == 0, "R3 six NOPs after REFRESH", acc_err, 0);
          ref_pos = -1; acc_err = 0;
        end
      end else if (ready && c == REF) begin
        if (last_ref > 0) chk(cyc - last_ref <= RP + 9, "R4 refresh gap", cyc - last_ref, RP + 9);
        last_ref = cyc; ref_pos = 1; acc_err = 0;
      end
      k = -1;
      if (cyc == rd_t + CL) k = rd_key;
      else if (cyc == rd_t + CL + 1) k = rd_key ^ 1;
      if (k >= 0) dq_in = mem.exists(k) ? mem[k] : fill(k);
      else dq_in = 16'h0;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  int accesses = 0;
  task automatic access(input logic we, input logic [AW-1:0] addr, input logic [31:0] wd);
    int got;
    logic [31:0] exp;
    int k;
    cur_we = we; req = 1'b1; h_we = we; h_addr = addr; h_wd = wd;
    while (busy) step();
    step();
    req = 1'b0;
    accesses++;
    chk(busy, "R8 busy during access", busy, 1);
    got = -1;
    for (int i = 0; i < 12; i++) begin
      step();
      if (rvalid) begin
        chk(got < 0, "R7 single strobe", 1, 0);
        if (got < 0) got = cyc;
        if (!we) begin
          k = int'(addr);
          exp = shadow.exists(k) ? shadow[k] : {fill(k ^ 1), fill(k)};
          chk(rdata == exp, "R7 read data", rdata, exp);
        end
      end
    end
    if (we) begin
      shadow[int'(addr)] = wd;
      chk(got < 0, "R7 no strobe on write", got, -1);
    end else begin
      chk(got == rd_t + CL + 2, "R7 strobe cycle", got, rd_t + CL + 2);
    end
    chk({m_ba, m_row, m_col} == addr && !m_a10, "R5 address fields", {m_a10, m_ba, m_row, m_col}, addr);
  endtask

  function automatic logic [AW-1:0] rnd_addr(input int pool);
    logic [AW-1:0] a;
    a = AW'($urandom);
    if (pool > 0) a = AW'({a[AW-1 -: 3], 18'h0, 3'(pool)});
    a[0] = 1'b0;
    return a;
  endfunction

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt == 150000) begin
      chk(0, "watchdog", wd_cnt, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [8];
    void'($urandom(32'h5EED_1234));
    repeat (3) step();
    chk(!ready && !rvalid && {cs_n, ras_n, cas_n, we_n} == NOP, "R1 reset state",
        {ready, rvalid, cs_n, ras_n, cas_n, we_n}, 6'b000111);
    req = 1'b1; h_we = 1'b0; h_addr = '0;
    rst_n = 1'b1;
    while (!ready) step();
    req = 1'b0;
    chk(init_n == 4, "R1 init command count", init_n, 4);
    chk(ev_cmd[0] == PRE && ev_addr[0][10], "R1 precharge all", {ev_cmd[0], ev_addr[0]}, {PRE, 13'h400});
    chk(ev_cyc[0] >= INIT && ev_cyc[0] <= INIT + 1, "R1 wait length", ev_cyc[0], INIT);
    chk(ev_cmd[1] == REF && ev_cyc[1] == ev_cyc[0] + 3, "R1 first refresh", ev_cyc[1] - ev_cyc[0], 3);
    chk(ev_cmd[2] == REF && ev_cyc[2] == ev_cyc[1] + 7, "R1 second refresh", ev_cyc[2] - ev_cyc[1], 7);
    chk(ev_cmd[3] == MRS && ev_cyc[3] == ev_cyc[2] + 7, "R1 mode load", ev_cyc[3] - ev_cyc[2], 7);
    chk(ev_addr[3] == RWD'((CL << 4) | 1), "R2 mode word", ev_addr[3], (CL << 4) | 1);
    chk(ready_cyc == ev_cyc[3] + 3, "R1 ready timing", ready_cyc - ev_cyc[3], 3);
    chk(act_before_ready == 0, "R8 request ignored before ready", act_before_ready, 0);
    access(1'b1, '0, 32'hCAFE_0001);
    access(1'b0, '0, '0);
    access(1'b1, {2'b11, 13'h1FFF, 9'h1FE}, 32'hFFFF_0000);
    access(1'b0, {2'b11, 13'h1FFF, 9'h1FE}, '0);
    access(1'b0, {2'b01, 13'h0123, 9'h010}, '0);
    for (int i = 0; i < 8; i++) pool[i] = rnd_addr(i + 1);
    for (int i = 0; i < 120; i++) begin
      logic w;
      w = ($urandom % 2) == 1;
      access(w, pool[$urandom % 8], $urandom);
    end
    repeat (300) step();
    chk(act_total == accesses, "R8 one activate per request", act_total, accesses);
    chk(last_ref > 0 && cyc - last_ref <= RP + 9, "R4 refresh while quiet", cyc - last_ref, RP + 9);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule